// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector

This block watches a single-bit serial line that is sampled on every rising clock edge. It flags each time the three-bit pattern one, zero, one arrives. The flag comes from the machine's state alone, so it is a Moore output. It rises in the clock cycle after the edge that captured the final one of the pattern, and it stays high for exactly that one cycle.

Matches do not overlap. Once a match completes, its closing one counts only as a possible fresh leading one. It can never serve as the one-zero prefix of the next match. The stream 1,0,1,0,1 therefore flags after the third bit and not after the fifth.

Internally a thin top joins two parts. The control part decodes the current state and the serial bit into a one-hot set of step strobes. The datapath part holds the two-bit state register and decodes the output from it. The state codes are idle 00, seen-one 01, seen-one-zero 10 and hit 11.

Top module: `pattern101_detector`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the machine returns to idle (code 00) and `matchOut` is 0 in the following cycle. A partial pattern seen before a reset never completes a match after it.
- R2: From idle, the sampled sequence 1,0,1 drives `matchOut` to 1 in the cycle after the edge that captured the last 1, and only then.
- R3: The stream 1,0,1,0,1 raises `matchOut` after the third bit and keeps it 0 after the fifth bit.
- R4: From the hit state (code 11), a sampled 1 moves to seen-one (code 01), never to seen-one-zero (code 10). So the stream 1,0,1,1,0,1 flags after bits three and six.
- R5: From seen-one-zero (code 10), a sampled 0 returns to idle (code 00). So 1,0,0,1 gives no flag.
- R6: In seen-one (code 01), a sampled 1 stays in seen-one. So 1,1,0,1 flags after the fourth bit.
- R7: `matchOut` is 1 only in the hit state and never stays high for two consecutive cycles.
- R8: Over arbitrary input streams, `matchOut` equals a non-overlapping search for 1,0,1 that restarts after every match and after every reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data bit, sampled every rising edge |
| matchOut | output | 1 | High for one cycle after a non-overlapping 1,0,1 completes |

## Verification
The block has no tunable parameters. Its only width, the two-bit state code, comes from the shared package, so the bench builds it as it stands. That two-bit code lets a few thousand random bits visit all four states and every state-input pair many times over. Directed streams add the cases that random input may reach only rarely: the match that restarts on a trailing one, the double zero that aborts a prefix, the repeated leading one, and a reset that lands in the middle of a partial pattern.

// File: rtl/pattern101_pkg.sv
package pattern101_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 2'b00,
    ST_ONE      = 2'b01,
    ST_ONE_ZERO = 2'b10,
    ST_HIT      = 2'b11
  } detState_e;

  // One-hot step request from control to datapath
  typedef struct packed {
    logic toIdle;
    logic toOne;
    logic toOneZero;
    logic toHit;
  } stepStrobe_t;

endpackage

// File: rtl/pattern101_ctrl.sv
module pattern101_ctrl
  import pattern101_pkg::*;
(
  input  detState_e   curState,
  input  logic        serialBit,
  output stepStrobe_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (curState)
      ST_IDLE: begin
        if (serialBit) strobes.toOne  = 1'b1;
        else           strobes.toIdle = 1'b1;
      end
      ST_ONE: begin
        if (serialBit) strobes.toOne     = 1'b1;
        else           strobes.toOneZero = 1'b1;
      end
      ST_ONE_ZERO: begin
        if (serialBit) strobes.toHit  = 1'b1;
        else           strobes.toIdle = 1'b1;
      end
      ST_HIT: begin
        // closing one may only act as a new leading one
        if (serialBit) strobes.toOne  = 1'b1;
        else           strobes.toIdle = 1'b1;
      end
      default: strobes.toIdle = 1'b1;
    endcase
  end

endmodule

// File: rtl/pattern101_state.sv
module pattern101_state
  import pattern101_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  stepStrobe_t strobes,
  output detState_e   curState,
  output logic        hitFlag
);

  detState_e nextState;

  always_comb begin
    nextState = ST_IDLE;
    if (strobes.toHit)          nextState = ST_HIT;
    else if (strobes.toOneZero) nextState = ST_ONE_ZERO;
    else if (strobes.toOne)     nextState = ST_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end

  assign hitFlag = (curState == ST_HIT);

endmodule

// File: rtl/pattern101_detector.sv
module pattern101_detector
  import pattern101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic matchOut
);

  detState_e   stateCode;
  stepStrobe_t stepReq;

  pattern101_ctrl uCtrl (
    .curState (stateCode),
    .serialBit(serialIn),
    .strobes  (stepReq)
  );

  pattern101_state uState (
    .clk     (clk),
    .rst     (rst),
    .strobes (stepReq),
    .curState(stateCode),
    .hitFlag (matchOut)
  );

endmodule

// File: rtl/pattern101_checker.sv
module pattern101_checker
  import pattern101_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                serialIn,
  input logic                matchOut,
  input logic [STATE_W-1:0]  stateCode
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (stateCode == ST_IDLE) && !matchOut);

  assert_hit_prefix_R2: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> $past(serialIn) && !$past(serialIn, 2) && $past(serialIn, 3));

  assert_hit_no_reuse_R4: assert property (@(posedge clk) disable iff (rst)
    (stateCode == ST_HIT) |=> (stateCode != ST_ONE_ZERO) && (stateCode != ST_HIT));

  assert_double_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ((stateCode == ST_ONE_ZERO) && !serialIn) |=> (stateCode == ST_IDLE));

  assert_repeat_one_R6: assert property (@(posedge clk) disable iff (rst)
    ((stateCode == ST_ONE) && serialIn) |=> (stateCode == ST_ONE));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    matchOut |=> !matchOut);

endmodule

bind pattern101_detector pattern101_checker uChecker (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .matchOut (matchOut),
  .stateCode(stateCode)
);

// File: tb/tb_pattern101_detector.sv
module tb_pattern101_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic matchOut;

  int checkCount = 0;
  int failCount  = 0;
  bit history[$];

  always #10 clk = ~clk;

  pattern101_detector dut (
    .clk     (clk),
    .rst     (rst),
    .serialIn(serialIn),
    .matchOut(matchOut)
  );

  task automatic check(input logic actual, input logic expected, input string req);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: matchOut=%0b expected=%0b at %0t", req, actual, expected, $time);
    end
  endtask

  // Drive one bit at a falling edge, let it be sampled, compare at the next falling edge.
  task automatic stepBit(input bit b, input string req);
    bit expHit;
    serialIn = b;
    @(posedge clk);
    history.push_back(b);
    expHit = 1'b0;
    if (history.size() >= 3 &&
        history[history.size()-3] == 1'b1 &&
        history[history.size()-2] == 1'b0 &&
        history[history.size()-1] == 1'b1) begin
      expHit = 1'b1;
      history.delete();
    end
    @(negedge clk);
    check(matchOut, expHit, req);
  endtask

  task automatic applyReset(input string req);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    history.delete();
    check(matchOut, 1'b0, req);
    rst = 1'b0;
  endtask

  task automatic runStream(input bit bits[$], input string req);
    foreach (bits[i]) stepBit(bits[i], req);
  endtask

  initial begin
    @(negedge clk);
    applyReset("R1");

    runStream('{1, 0, 1}, "R2");
    runStream('{0, 0}, "R2");
    applyReset("R1");
    runStream('{1, 0, 1, 0, 1}, "R3");
    applyReset("R1");
    runStream('{1, 0, 1, 1, 0, 1}, "R4");
    applyReset("R1");
    runStream('{1, 0, 0, 1}, "R5");
    applyReset("R1");
    runStream('{1, 1, 0, 1}, "R6");
    runStream('{1, 0, 1, 0, 1, 0, 1}, "R7");

    // partial prefix cut by reset must not complete (R1)
    applyReset("R1");
    runStream('{1, 0}, "R1");
    applyReset("R1");
    stepBit(1, "R1");
    stepBit(0, "R1");

    applyReset("R1");
    for (int i = 0; i < 3000; i++) begin
      stepBit(1'($urandom_range(0, 1)), "R8");
      if (i % 977 == 500) applyReset("R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failCount++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule